// File: doc/BRIEF.md
# Power-Down Clock Stop Sequencer

This block sits between the clock sources of a clock generator and its output drivers. It stops a set of single-ended clocks and true/complement differential pairs cleanly when an asynchronous, active-low power-down request arrives. It restarts them without glitches when the request is withdrawn. Once every output has reached its stopped state, it raises a request to turn the oscillator off.

The request is sampled on the rising edges of the reference pair's complement clock. A stop is decided only after the request has been seen low at two consecutive such edges. The decision then passes through a short synchronizer into every output's own clock domain. Single-ended outputs park low at a falling edge of their source. Differential pairs park with true high and complement low at a falling edge of their complement. Each pair then floats as its drive-mode bit selects:
- With the bit at 0, the true output stays driven high and the complement is released.
- With the bit at 1, both outputs are released.

On release, a pair first drives both outputs again in the parked levels for one full period, and only then resumes toggling.

Top module: `clkstop_seq`

## Requirements
- R1: While reset is held, and afterwards with pd_n high, every output follows its source clock, every output enable is 1 and vco_off is 0.
- R2: A stop is decided only when pd_n is low at two consecutive rising edges of dp_clk_c[REF_PAIR] (pair 0 by default); a low seen at a single such edge leaves every output running.
- R3: Each se_clk_out bit parks low starting at a falling edge of its source, and every high pulse it ever produces lasts the full source high time.
- R4: Each differential pair parks with dp_out_t = 1 and dp_out_c = 0, starting at a falling edge of its complement; every low pulse on dp_out_t lasts a full half period.
- R5: For a pair with dp_mode bit 0, once stopped dp_oe_t stays 1 and dp_oe_c is 0.
- R6: For a pair with dp_mode bit 1, once stopped both dp_oe_t and dp_oe_c are 0.
- R7: vco_off rises only while every se_clk_out bit is 0, every dp_out_t bit is 1 and every dp_oe_c bit is 0; it returns to 0 in the same instant pd_n returns high.
- R8: On release, each pair drives both outputs (both enables 1, true 1, complement 0) for at least one full period of its clock before dp_out_t first falls; all outputs then follow their sources again.
- R9: The dp_mode bits act on their own pair only; different bit patterns give the matching enable pattern per pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| dp_mode | input | N_DP | Per-pair stopped behaviour: 0 true driven high, 1 both floated |
| se_clk_in | input | N_SE | Single-ended source clocks |
| dp_clk_t | input | N_DP | True side of differential source clocks |
| dp_clk_c | input | N_DP | Complement side of differential source clocks |
| se_clk_out | output | N_SE | Gated single-ended clocks |
| dp_out_t | output | N_DP | Gated true outputs |
| dp_out_c | output | N_DP | Gated complement outputs |
| dp_oe_t | output | N_DP | Output enable for true outputs |
| dp_oe_c | output | N_DP | Output enable for complement outputs |
| vco_off | output | 1 | Request to turn the oscillator off |

## Verification
The bench drives seven free-running clocks of unrelated periods. It applies a power-down low that spans only one reference edge, which separates a correct two-sample decision from a one-sample one. It applies sustained power-down requests under three drive-mode patterns (mixed, the inverse mix, and all driven), which tell a per-pair enable decision from a shared one and driven parking from floating. Every release is timed per pair from the re-drive of both enables to the first falling true edge, which exposes a design that resumes toggling straight from the floating state. Pulse-width monitors on every output catch any runt pulse produced at a stop or a restart.

// File: rtl/clkstop_seq.sv
module clkstop_seq #(
  parameter int N_SE     = 4,
  parameter int N_DP     = 3,
  parameter int REF_PAIR = 0,
  parameter int SYNC_LEN = 2
) (
  input  logic            rst_n,
  input  logic            pd_n,
  input  logic [N_DP-1:0] dp_mode,
  input  logic [N_SE-1:0] se_clk_in,
  input  logic [N_DP-1:0] dp_clk_t,
  input  logic [N_DP-1:0] dp_clk_c,
  output logic [N_SE-1:0] se_clk_out,
  output logic [N_DP-1:0] dp_out_t,
  output logic [N_DP-1:0] dp_out_c,
  output logic [N_DP-1:0] dp_oe_t,
  output logic [N_DP-1:0] dp_oe_c,
  output logic            vco_off
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NOUT = N_SE + N_DP;
  localparam int PIPE = SYNC_LEN * NOUT;

  typedef enum logic [1:0] {RUN = 2'd0, PARK = 2'd1, FLOAT = 2'd2} park_t;

  logic            dclk;
  logic [1:0]      pd_seen;
  logic            stop_q;
  logic            vco_q;
  logic [NOUT-1:0] parked;
  logic [PIPE-1:0] park_pipe;
  logic [NOUT-1:0] park_seen;

  assign dclk      = dp_clk_c[REF_PAIR];
  assign park_seen = park_pipe[PIPE-1 -: NOUT];
  assign vco_off   = vco_q & ~pd_n;

  always_ff @(posedge dclk or negedge rst_n)
    if (!rst_n) begin
      pd_seen   <= '1;
      stop_q    <= 1'b0;
      park_pipe <= '0;
      vco_q     <= 1'b0;
    end else begin
      pd_seen   <= {pd_seen[0], pd_n};
      stop_q    <= ~|pd_seen;
      park_pipe <= {park_pipe[PIPE-NOUT-1:0], parked};
      vco_q     <= stop_q & (&park_seen);
    end

  // R2
  two_low_samples_chk: assert property (@(posedge dclk) disable iff (!rst_n)
    $rose(stop_q) |-> (!$past(pd_n, 2) && !$past(pd_n, 3)));

  // R7
  vco_after_park_chk: assert property (@(posedge dclk) disable iff (!rst_n)
    vco_off |-> (se_clk_out == '0 && (&dp_out_t) && dp_oe_c == '0));

  for (genvar i = 0; i < N_SE; i++) begin : g_se
    logic [SYNC_LEN-1:0] sy;
    logic                en_q;

    always_ff @(posedge se_clk_in[i] or negedge rst_n)
      if (!rst_n) sy <= '0;
      else        sy <= {sy[SYNC_LEN-2:0], stop_q};

    always_ff @(negedge se_clk_in[i] or negedge rst_n)
      if (!rst_n) en_q <= 1'b1;
      else        en_q <= ~sy[SYNC_LEN-1];

    assign se_clk_out[i] = se_clk_in[i] & en_q;
    assign parked[i]     = ~en_q;
  end

  for (genvar j = 0; j < N_DP; j++) begin : g_dp
    logic [SYNC_LEN-1:0] sy;
    logic                stop_l;
    park_t               st;

    assign stop_l = sy[SYNC_LEN-1];

    always_ff @(posedge dp_clk_c[j] or negedge rst_n)
      if (!rst_n) sy <= '0;
      else        sy <= {sy[SYNC_LEN-2:0], stop_q};

    always_ff @(negedge dp_clk_c[j] or negedge rst_n)
      if (!rst_n) st <= RUN;
      else
        case (st)
          RUN:     if (stop_l) st <= PARK;
          PARK:    st <= stop_l ? FLOAT : RUN;
          default: if (!stop_l) st <= PARK;
        endcase

    assign dp_out_t[j]      = (st != RUN) | dp_clk_t[j];
    assign dp_out_c[j]      = (st == RUN) & dp_clk_c[j];
    assign dp_oe_t[j]       = !((st == FLOAT) && dp_mode[j]);
    assign dp_oe_c[j]       = (st != FLOAT);
    assign parked[N_SE + j] = (st == FLOAT);

    // R4
    park_is_transient_chk: assert property (@(negedge dp_clk_c[j]) disable iff (!rst_n)
      (st == PARK) |=> (st != PARK));

    // R8
    float_exit_via_park_chk: assert property (@(negedge dp_clk_c[j]) disable iff (!rst_n)
      (st == RUN) |-> ($past(st) != FLOAT));
  end
endmodule

// File: tb/clkstop_seq_test.sv
module clkstop_seq_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 0, rst_n = 1, pd_n = 1;
  logic [2:0] dp_mode = 3'b000;
  logic s0 = 0, s1 = 0, s2 = 0, s3 = 0, p1 = 0, p2 = 0;
  logic [3:0] se_in, se_out;
  logic [2:0] dp_t, dp_c, out_t, out_c, oe_t, oe_c;
  logic vco_off;
  int n_chk = 0, n_bad = 0;

  always #4  clk = ~clk;
  always #5  p1 = ~p1;
  always #6  p2 = ~p2;
  always #8  s0 = ~s0;
  always #12 s1 = ~s1;
  always #15 s2 = ~s2;
  always #35 s3 = ~s3;

  assign se_in = {s3, s2, s1, s0};
  assign dp_t  = {p2, p1, clk};
  assign dp_c  = ~dp_t;

  clkstop_seq uut (
    .rst_n(rst_n), .pd_n(pd_n), .dp_mode(dp_mode),
    .se_clk_in(se_in), .dp_clk_t(dp_t), .dp_clk_c(dp_c),
    .se_clk_out(se_out), .dp_out_t(out_t), .dp_out_c(out_c),
    .dp_oe_t(oe_t), .dp_oe_c(oe_c), .vco_off(vco_off)
  );

  function automatic int se_half(int i);
    case (i)
      0: return 8;
      1: return 12;
      2: return 15;
      default: return 35;
    endcase
  endfunction

  function automatic int dp_period(int j);
    case (j)
      0: return 8;
      1: return 10;
      default: return 12;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // R3 runt monitors on single-ended outputs
  for (genvar i = 0; i < 4; i++) begin : m_se
    realtime rt = -1.0;
    int runts = 0;
    always @(posedge se_out[i]) if (rst_n) rt = $realtime;
    always @(negedge se_out[i])
      if (rst_n && rt >= 0.0 && ($realtime - rt) != real'(se_half(i))) runts++;
  end

  // R4 runt monitors on true outputs
  for (genvar j = 0; j < 3; j++) begin : m_dp
    realtime ft = -1.0;
    int runts = 0;
    always @(negedge out_t[j]) if (rst_n) ft = $realtime;
    always @(posedge out_t[j])
      if (rst_n && ft >= 0.0 && ($realtime - ft) != real'(dp_period(j)) / 2.0) runts++;
  end

  // R7 every rise of vco_off must find all outputs parked
  always @(posedge vco_off)
    if (rst_n) begin
      #0.1;
      chk(se_out == 4'b0 && out_t == 3'b111 && oe_c == 3'b000, "R7", "parked at vco_off rise",
          32'({se_out, out_t, oe_c}), 32'({4'b0000, 3'b111, 3'b000}));
    end

  task automatic check_running(input string req);
    bit ok = 1;
    repeat (12) begin
      @(posedge clk); #0.5;
      if (se_out != se_in || out_t != dp_t || out_c != dp_c || oe_t != 3'b111 || oe_c != 3'b111)
        ok = 0;
    end
    chk(ok, req, "outputs follow sources", 32'({se_out, out_t, out_c}), 32'({se_in, dp_t, dp_c}));
  endtask

  task automatic t_reset;
    #1 rst_n = 0;
    repeat (4) @(posedge clk);
    #0.5;
    chk(vco_off == 1'b0, "R1", "vco_off in reset", 32'(vco_off), 32'(0));
    chk(oe_t == 3'b111 && oe_c == 3'b111, "R1", "enables in reset", 32'({oe_t, oe_c}), 32'(6'h3f));
    rst_n = 1;
    repeat (6) @(posedge clk);
    check_running("R1");
  endtask

  task automatic t_single_low;
    @(posedge clk);
    #1 pd_n = 0;
    #5 pd_n = 1;
    repeat (30) @(posedge clk);
    #0.5;
    chk(vco_off == 1'b0, "R2", "vco_off after one-edge low", 32'(vco_off), 32'(0));
    check_running("R2");
  endtask

  task automatic t_stop(input logic [2:0] mode);
    dp_mode = mode;
    repeat (2) @(posedge clk);
    #1 pd_n = 0;
    repeat (100) @(posedge clk);
    #0.5;
    chk(se_out == 4'b0000, "R3", "single-ended parked low", 32'(se_out), 32'(0));
    chk(out_t == 3'b111 && out_c == 3'b000, "R4", "pairs parked true high",
        32'({out_t, out_c}), 32'({3'b111, 3'b000}));
    chk(oe_c == 3'b000, "R5", "complement enables released", 32'(oe_c), 32'(0));
    chk(oe_t == ~mode, "R6", "true enables follow mode", 32'(oe_t), 32'(~mode));
    chk(oe_t == ~mode, "R9", "per-pair enable pattern", 32'(oe_t), 32'(~mode));
    chk(vco_off == 1'b1, "R7", "vco_off raised", 32'(vco_off), 32'(1));
    repeat (7) @(posedge clk);
    #0.5;
    chk(se_out == 4'b0000 && out_t == 3'b111, "R4", "park holds",
        32'({se_out, out_t}), 32'({4'b0000, 3'b111}));
  endtask

  task automatic measure(input int j);
    realtime t0;
    wait (oe_t[j] === 1'b1 && oe_c[j] === 1'b1);
    t0 = $realtime;
    #0.1;
    chk(out_t[j] === 1'b1 && out_c[j] === 1'b0, "R8", "re-driven park levels",
        32'({out_t[j], out_c[j]}), 32'(2'b10));
    wait (out_t[j] === 1'b0);
    chk(($realtime - t0) >= real'(dp_period(j)), "R8", "drive time before first toggle",
        32'(int'($realtime - t0)), 32'(dp_period(j)));
  endtask

  task automatic t_release;
    pd_n = 1;
    #0.5;
    chk(vco_off == 1'b0, "R7", "vco_off drops on release", 32'(vco_off), 32'(0));
    fork
      measure(0);
      measure(1);
      measure(2);
    join
    repeat (60) @(posedge clk);
    check_running("R8");
  endtask

  initial begin
    t_reset;
    t_single_low;
    t_stop(3'b010);
    t_release;
    t_stop(3'b101);
    t_release;
    t_stop(3'b000);
    t_release;
    chk(m_se[0].runts + m_se[1].runts + m_se[2].runts + m_se[3].runts == 0, "R3",
        "single-ended runt pulses",
        32'(m_se[0].runts + m_se[1].runts + m_se[2].runts + m_se[3].runts), 32'(0));
    chk(m_dp[0].runts + m_dp[1].runts + m_dp[2].runts == 0, "R4", "true-output runt pulses",
        32'(m_dp[0].runts + m_dp[1].runts + m_dp[2].runts), 32'(0));
    summary;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R8 watchdog: actual 150000 cycles expected completion");
    summary;
    $finish;
  end
endmodule